// File: doc/BRIEF.md
# Memory Field Extension Controller

This block widens the reach of a 12-bit minicomputer from one 4K word space to eight 4K fields. It keeps two live 3-bit field numbers: one selects where instructions are fetched (the instruction field) and one selects where indirect data operands go (the data field). The CPU sequencer passes it every I/O transfer instruction together with a valid strobe. It also sends a strobe when an interrupt is taken and a strobe at the moment a jump or subroutine call reloads the field.

A change of instruction field is not applied at once. The new field waits in a 3-bit buffer, and a pending flag holds off interrupts until the next jump or subroutine call copies the buffer into the live field. When an interrupt is taken, the live fields are packed into a 6-bit save register and all fields return to 0. Read instructions OR field values or the saved pair into the accumulator, and a restore instruction reloads the data field and the buffer from the save register.

Bits are numbered most-significant first: bit 0 of a 12-bit word is its MSB. The field group is every instruction whose bits 0–5 are octal 62. In that group, bits 6–8 (Verilog [5:3]) carry a field number or a read selector, and bits 9–11 (Verilog [2:0]) choose the operation.

Top module: `mem_field_ctrl`

## Requirements
- R1: After reset, cur_if, cur_df and int_inhibit are 0, and the save register reads back as 0.
- R2: A valid group instruction with low bits 001 loads instruction bits [5:3] into the data field. The new value is seen on cur_df from the next cycle, and cur_if does not change.
- R3: A valid group instruction with low bits 010 loads bits [5:3] into the buffer and sets the pending flag. int_inhibit is 1 from the next cycle, and cur_if does not change.
- R4: A pulse on jmp_reload copies the buffer into the instruction field and clears the pending flag, both seen from the next cycle. cur_if changes on no other event except an interrupt.
- R5: A pulse on intr_taken stores {IF, DF} in the save register, with IF in bits [5:3] and DF in bits [2:0]. It then clears IF, DF and the buffer to 0 from the next cycle and leaves the pending flag as it was.
- R6: While a valid group instruction with low bits 100 and selector 001 is present, acc_out = acc_in | (DF << 3). With selector 010, acc_out = acc_in | (IF << 3). Both are combinational.
- R7: With low bits 100 and selector 011, acc_out = acc_in | SF, zero-extended. The saved IF lands in acc bits [5:3] and the saved DF in bits [2:0].
- R8: With low bits 100 and selector 100, DF loads from SF[2:0], the buffer loads from SF[5:3] and the pending flag is set. The next jmp_reload then restores the saved IF.
- R9: Low bits 011 perform the R2 and R3 actions together in one cycle, both with the same field value.
- R10: Priority is intr_taken, then jmp_reload, then the instruction. An instruction whose bits [11:6] are not octal 62, or whose iot_valid is 0, changes no state.
- R11: acc_out equals acc_in whenever no read selector (001, 010 or 011 with low bits 100) is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| iot_valid | input | 1 | instr holds an I/O transfer instruction this cycle |
| instr | input | 12 | Instruction word |
| acc_in | input | 12 | Current accumulator value |
| intr_taken | input | 1 | Interrupt is being taken this cycle |
| jmp_reload | input | 1 | Jump or call reloads the instruction field this cycle |
| cur_if | output | 3 | Live instruction field |
| cur_df | output | 3 | Live data field |
| acc_out | output | 12 | Accumulator with field value ORed in |
| int_inhibit | output | 1 | Blocks interrupts while a field change is pending |

## Verification
The bench targets these corner cases:
- A field change followed by further instructions before the jump. A design that applied the change early would move cur_if too soon.
- An interrupt, then a save read and a restore. Swapping the two halves of the save register would give back IF and DF in the wrong bit positions.
- An interrupt that arrives together with a field load. A design with the wrong priority would keep the loaded field instead of 0.
- Instructions outside the group, and the combined load instruction. A loose opcode decode would change the fields or the inhibit output when it should not.

// File: rtl/mfc_pkg.sv
// Shared constants and the decoded command type for the memory field
// extension controller. Bit numbering is MSB-first in the documentation;
// Verilog indices here are the usual LSB-first ones.
package mfc_pkg;
    localparam int WORD_W    = 12;
    localparam int FIELD_W   = 3;
    localparam int SAVE_W    = 2 * FIELD_W;
    localparam int GROUP_W   = WORD_W - 2 * FIELD_W;
    localparam logic [GROUP_W-1:0] GROUP_CODE = 6'o62;
    localparam int FLD_LSB   = FIELD_W;          // instr[5:3]
    localparam int ACC_SHIFT = FIELD_W;          // acc bits 6..8 (MSB-first)

    typedef struct packed {
        logic ld_df;   // load data field from instruction
        logic ld_ib;   // load buffer from instruction, set pending
        logic rd_df;   // OR data field into accumulator
        logic rd_if;   // OR instruction field into accumulator
        logic rd_sf;   // OR save register into accumulator
        logic rst_sf;  // restore data field and buffer from save register
    } mfc_cmd_t;
endpackage

// File: rtl/mfc_iot_decode.sv
// Decodes a field-group I/O instruction into one-hot-ish command bits.
// Assumes instr is stable while iot_valid is high; purely combinational.
module mfc_iot_decode
    import mfc_pkg::*;
(
    input  logic               iot_valid,
    input  logic [WORD_W-1:0]  instr,
    output mfc_cmd_t           cmd,
    output logic [FIELD_W-1:0] fld
);
    logic in_group;
    logic [FIELD_W-1:0] op;

    assign in_group = iot_valid && (instr[WORD_W-1 -: GROUP_W] == GROUP_CODE);
    assign fld      = instr[FLD_LSB +: FIELD_W];
    assign op       = instr[FIELD_W-1:0];

    // Map low operation bits and selector to command bits.
    always_comb begin
        cmd = '0;
        if (in_group) begin
            case (op)
                3'd1: cmd.ld_df = 1'b1;
                3'd2: cmd.ld_ib = 1'b1;
                3'd3: begin
                    cmd.ld_df = 1'b1;
                    cmd.ld_ib = 1'b1;
                end
                3'd4: begin
                    case (fld)
                        3'd1:    cmd.rd_df  = 1'b1;
                        3'd2:    cmd.rd_if  = 1'b1;
                        3'd3:    cmd.rd_sf  = 1'b1;
                        3'd4:    cmd.rst_sf = 1'b1;
                        default: cmd = '0;
                    endcase
                end
                default: cmd = '0;
            endcase
        end
    end
endmodule

// File: rtl/mfc_field_regs.sv
// Holds instruction field, data field, buffer, save register and pending
// flag. Priority: interrupt, then jump reload, then decoded command.
// Assumes the sequencer never takes an interrupt while int_inhibit is high.
module mfc_field_regs
    import mfc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  mfc_cmd_t           cmd,
    input  logic [FIELD_W-1:0] fld,
    input  logic               intr_taken,
    input  logic               jmp_reload,
    output logic [FIELD_W-1:0] if_q,
    output logic [FIELD_W-1:0] df_q,
    output logic [SAVE_W-1:0]  sf_q,
    output logic               ii_q
);
    logic [FIELD_W-1:0] ib_q;

    // Update all field state on the clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if_q <= '0;
            df_q <= '0;
            ib_q <= '0;
            sf_q <= '0;
            ii_q <= 1'b0;
        end else if (intr_taken) begin
            sf_q <= {if_q, df_q};
            if_q <= '0;
            df_q <= '0;
            ib_q <= '0;
        end else if (jmp_reload) begin
            if_q <= ib_q;
            ii_q <= 1'b0;
        end else begin
            if (cmd.ld_df) df_q <= fld;
            if (cmd.ld_ib) begin
                ib_q <= fld;
                ii_q <= 1'b1;
            end
            if (cmd.rst_sf) begin
                df_q <= sf_q[FIELD_W-1:0];
                ib_q <= sf_q[SAVE_W-1:FIELD_W];
                ii_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/mfc_acc_merge.sv
// Builds the accumulator result by ORing a field value chosen by the
// decoded read command into acc_in. Combinational; at most one read is set.
module mfc_acc_merge
    import mfc_pkg::*;
(
    input  mfc_cmd_t           cmd,
    input  logic [FIELD_W-1:0] if_q,
    input  logic [FIELD_W-1:0] df_q,
    input  logic [SAVE_W-1:0]  sf_q,
    input  logic [WORD_W-1:0]  acc_in,
    output logic [WORD_W-1:0]  acc_out
);
    logic [WORD_W-1:0] mask;

    // Select the value to merge into the accumulator.
    always_comb begin
        mask = '0;
        if (cmd.rd_df) mask = WORD_W'(df_q) << ACC_SHIFT;
        if (cmd.rd_if) mask = WORD_W'(if_q) << ACC_SHIFT;
        if (cmd.rd_sf) mask = WORD_W'(sf_q);
    end

    assign acc_out = acc_in | mask;
endmodule

// File: rtl/mem_field_ctrl.sv
// Top of the memory field extension controller. Wires decoder, field
// registers and accumulator merge. Field outputs are registered; acc_out
// is combinational from instr, acc_in and the registered state.
module mem_field_ctrl
    import mfc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               iot_valid,
    input  logic [WORD_W-1:0]  instr,
    input  logic [WORD_W-1:0]  acc_in,
    input  logic               intr_taken,
    input  logic               jmp_reload,
    output logic [FIELD_W-1:0] cur_if,
    output logic [FIELD_W-1:0] cur_df,
    output logic [WORD_W-1:0]  acc_out,
    output logic               int_inhibit
);
    mfc_cmd_t           cmd;
    logic [FIELD_W-1:0] fld;
    logic [SAVE_W-1:0]  sf_q;

    mfc_iot_decode u_dec (
        .iot_valid (iot_valid),
        .instr     (instr),
        .cmd       (cmd),
        .fld       (fld)
    );

    mfc_field_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd        (cmd),
        .fld        (fld),
        .intr_taken (intr_taken),
        .jmp_reload (jmp_reload),
        .if_q       (cur_if),
        .df_q       (cur_df),
        .sf_q       (sf_q),
        .ii_q       (int_inhibit)
    );

    mfc_acc_merge u_acc (
        .cmd     (cmd),
        .if_q    (cur_if),
        .df_q    (cur_df),
        .sf_q    (sf_q),
        .acc_in  (acc_in),
        .acc_out (acc_out)
    );
endmodule

// File: rtl/mfc_checker.sv
// Port-level temporal checks for mem_field_ctrl, bound to every instance.
module mfc_checker
    import mfc_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               iot_valid,
    input logic [WORD_W-1:0]  instr,
    input logic [WORD_W-1:0]  acc_in,
    input logic               intr_taken,
    input logic               jmp_reload,
    input logic [FIELD_W-1:0] cur_if,
    input logic [FIELD_W-1:0] cur_df,
    input logic [WORD_W-1:0]  acc_out,
    input logic               int_inhibit
);
    logic grp;
    logic quiet;
    logic is_read;
    assign grp     = iot_valid && (instr[11:6] == 6'o62);
    assign quiet   = !intr_taken && !jmp_reload;
    assign is_read = grp && (instr[2:0] == 3'd4) &&
                     (instr[5:3] == 3'd1 || instr[5:3] == 3'd2 || instr[5:3] == 3'd3);

    p_cdf_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (grp && (instr[2:0] == 3'd1 || instr[2:0] == 3'd3) && quiet)
        |=> (cur_df == $past(instr[5:3])));

    p_cif_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grp && (instr[2:0] == 3'd2 || instr[2:0] == 3'd3) && quiet)
        |=> (int_inhibit && $stable(cur_if)));

    p_reload_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_reload && !intr_taken) |=> !int_inhibit);

    p_if_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> $stable(cur_if));

    p_intr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        intr_taken |=> (cur_if == 3'd0 && cur_df == 3'd0));

    p_acc_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !is_read |-> (acc_out == acc_in));
endmodule

bind mem_field_ctrl mfc_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .iot_valid   (iot_valid),
    .instr       (instr),
    .acc_in      (acc_in),
    .intr_taken  (intr_taken),
    .jmp_reload  (jmp_reload),
    .cur_if      (cur_if),
    .cur_df      (cur_df),
    .acc_out     (acc_out),
    .int_inhibit (int_inhibit)
);

// File: tb/tb_mem_field_ctrl.sv
`timescale 1ns/1ps
module tb_mem_field_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        iot_valid = 1'b0;
    logic [11:0] instr = '0;
    logic [11:0] acc_in = '0;
    logic        intr_taken = 1'b0;
    logic        jmp_reload = 1'b0;
    logic [2:0]  cur_if;
    logic [2:0]  cur_df;
    logic [11:0] acc_out;
    logic        int_inhibit;

    int checks = 0;
    int failures = 0;

    // Reference model state
    logic [2:0] m_if = '0, m_df = '0, m_ib = '0;
    logic [5:0] m_sf = '0;
    logic       m_ii = 1'b0;

    always #10 clk = ~clk;

    mem_field_ctrl dut (
        .clk(clk), .rst_n(rst_n), .iot_valid(iot_valid), .instr(instr),
        .acc_in(acc_in), .intr_taken(intr_taken), .jmp_reload(jmp_reload),
        .cur_if(cur_if), .cur_df(cur_df), .acc_out(acc_out),
        .int_inhibit(int_inhibit)
    );

    function automatic logic [11:0] exp_acc(logic v, logic [11:0] ins, logic [11:0] a);
        logic [11:0] r = a;
        if (v && ins[11:6] == 6'o62 && ins[2:0] == 3'd4) begin
            case (ins[5:3])
                3'd1: r = a | {6'd0, m_df, 3'd0};
                3'd2: r = a | {6'd0, m_if, 3'd0};
                3'd3: r = a | {6'd0, m_sf};
                default: r = a;
            endcase
        end
        return r;
    endfunction

    task automatic model_update(logic v, logic [11:0] ins, logic it, logic jr);
        logic g = v && ins[11:6] == 6'o62;
        if (it) begin
            m_sf = {m_if, m_df};
            m_if = 0; m_df = 0; m_ib = 0;
        end else if (jr) begin
            m_if = m_ib; m_ii = 0;
        end else if (g) begin
            if (ins[2:0] == 3'd1 || ins[2:0] == 3'd3) m_df = ins[5:3];
            if (ins[2:0] == 3'd2 || ins[2:0] == 3'd3) begin m_ib = ins[5:3]; m_ii = 1; end
            if (ins[2:0] == 3'd4 && ins[5:3] == 3'd4) begin
                m_df = m_sf[2:0]; m_ib = m_sf[5:3]; m_ii = 1;
            end
        end
    endtask

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0o expected=%0o", tag, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus at a negedge, check acc, then state after the edge.
    task automatic step(logic v, logic [11:0] ins, logic [11:0] a, logic it, logic jr, string tag);
        iot_valid = v; instr = ins; acc_in = a; intr_taken = it; jmp_reload = jr;
        #1;
        check(tag, "acc_out", acc_out, exp_acc(v, ins, a));
        @(posedge clk);
        model_update(v, ins, it, jr);
        @(negedge clk);
        iot_valid = 0; intr_taken = 0; jmp_reload = 0;
        check(tag, "cur_if", cur_if, m_if);
        check(tag, "cur_df", cur_df, m_df);
        check(tag, "int_inhibit", int_inhibit, m_ii);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, and save register reads 0
        check("R1", "cur_if", cur_if, 0);
        check("R1", "cur_df", cur_df, 0);
        check("R1", "int_inhibit", int_inhibit, 0);
        step(1, 12'o6234, 12'o0000, 0, 0, "R1");
        // R2: field load of data field
        step(1, 12'o6231, 12'o0000, 0, 0, "R2");
        // R3: buffered instruction field, pending
        step(1, 12'o6252, 12'o0000, 0, 0, "R3");
        step(1, 12'o6241, 12'o0000, 0, 0, "R3");   // other work, IF still 0
        // R4: reload
        step(0, 12'o0000, 12'o0000, 0, 1, "R4");
        // R6: read DF and IF
        step(1, 12'o6214, 12'o0000, 0, 0, "R6");
        step(1, 12'o6224, 12'o7007, 0, 0, "R6");
        // R5: interrupt saves and clears
        step(0, 12'o0000, 12'o0000, 1, 0, "R5");
        // R7: read save register
        step(1, 12'o6234, 12'o0000, 0, 0, "R7");
        check("R7", "sf_readback", exp_acc(1, 12'o6234, 0), 12'o0054);
        // R8: restore then reload
        step(1, 12'o6244, 12'o0000, 0, 0, "R8");
        step(0, 12'o0000, 12'o0000, 0, 1, "R8");
        check("R8", "restored_if", cur_if, 5);
        // R9: combined load
        step(1, 12'o6273, 12'o0000, 0, 0, "R9");
        step(0, 12'o0000, 12'o0000, 0, 1, "R9");
        // R10: outside group and invalid strobe ignored; priorities
        step(1, 12'o6031, 12'o0000, 0, 0, "R10");
        step(0, 12'o6211, 12'o0000, 0, 0, "R10");
        step(1, 12'o6262, 12'o0000, 1, 0, "R10");
        step(1, 12'o6231, 12'o0000, 0, 1, "R10");
        // R11: pass-through on a non-read
        step(1, 12'o6254, 12'o1234, 0, 0, "R11");
        // Random mix
        for (int i = 0; i < 4000; i++) begin
            logic [11:0] ins;
            logic v, it, jr;
            ins = {($urandom % 4 != 0) ? 6'o62 : 6'($urandom), 3'($urandom), 3'($urandom % 8)};
            v  = ($urandom % 8) != 0;
            it = ($urandom % 16) == 0;
            jr = ($urandom % 6) == 0;
            step(v, ins, 12'($urandom), it, jr, "R10");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule